// File: doc/BRIEF.md
# Clear-on-read performance error counter

This block accumulates single-cycle performance error events from a DS3 receiver. A microprocessor reads the count over a byte-wide read port. Each read of the count also clears it. A width-select pin picks the counter width. With the pin low, the counter is 16 bits wide, the count address returns the low byte, and the read copies the high byte into a shared holding register that is read at its own strobe. With the pin high, the counter is 8 bits wide.

A read of the count may last several cycles. During that time the count is frozen, so the value on the port cannot change under the reader. The clear is applied in the cycle after the read strobe drops. An event that arrives during the read, or in that clearing cycle, is not lost. One such event is remembered, and the counter restarts at 1 instead of 0. Any further events in the same window are discarded.

No event is counted while loss of signal or out of frame is reported. The format-mode input sets the overflow behaviour. In M13 mode the count saturates at its maximum. In C-bit parity mode it wraps around. In C-bit parity mode the events are far-end block errors, which the upstream logic flags when any of the three far-end block error bits in a frame is received as 0. In M13 mode the events are framing-bit and multiframe-bit errors. Producing these events is left to the upstream logic.

Top module: `perfCount`

## Requirements
- R1: While `rdCount` is high, `rdData` shows bits 7:0 of the count, and the count does not change for as long as `rdCount` stays high.
- R2: In the first cycle after `rdCount` falls, the count is cleared to 0 if no event was retained.
- R3: A countable event that arrives while `rdCount` is high, or in the clearing cycle, is retained, and the count restarts at 1.
- R4: At most one event is retained per read window. Any further events in that window are discarded, so the count restarts at 1 no matter how many arrived.
- R5: An event is neither counted nor retained while `losIn` or `oofIn` is 1.
- R6: With `narrowSel` = 0, the counter is 16 bits wide and counts past 255. `rdCount` returns bits 7:0.
- R7: With `narrowSel` = 0, the rising edge of `rdCount` copies count bits 15:8 into the holding register, which `rdHold` places on `rdData`. With `narrowSel` = 1, a read leaves the holding register unchanged.
- R8: With `narrowSel` = 1, the counter is 8 bits wide. In C-bit parity mode it wraps from 255 to 0, and bits 15:8 stay 0.
- R9: With `modeM13` = 1, the counter saturates at its maximum: 255 when 8 bits wide, 65535 when 16 bits wide. With `modeM13` = 0, it wraps.
- R10: Reading the holding register (`rdHold`) leaves the count and the holding register unchanged.
- R11: After reset, the count and the holding register are 0. `rdData` is 0 when neither strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eventIn | input | 1 | One-cycle error event pulse |
| modeM13 | input | 1 | 1 = M13 format (saturating), 0 = C-bit parity (wrapping) |
| narrowSel | input | 1 | 1 = 8-bit counter, 0 = 16-bit counter |
| losIn | input | 1 | Loss of signal; inhibits counting |
| oofIn | input | 1 | Out of frame; inhibits counting |
| rdCount | input | 1 | Count read strobe; may span several cycles, clears on release |
| rdHold | input | 1 | Holding-register read strobe |
| rdData | output | 8 | Read data (count low byte has priority over holding register) |

## Verification
The bench builds the block with its default parameters: a 16-bit full counter and an 8-bit byte lane. With these values, the 8-bit wrap point and the 16-bit saturation and wrap points can all be reached by plain event streams of about 65,600 pulses, with the holding register read after each one. Directed sequences cover multi-cycle reads with events in every cycle, an event in the clearing cycle, and inhibited events during a read.

// File: rtl/perfCountPkg.sv
package perfCountPkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic incr;     // add one to the count
    logic clear;    // load the post-read restart value
    logic loadOne;  // restart value is 1 (an event was retained)
    logic capHigh;  // copy the upper byte into the holding register
  } strobe_t;

endpackage

// File: rtl/perfCountCtrl.sv
module perfCountCtrl
  import perfCountPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    eventIn,
  input  logic    losIn,
  input  logic    oofIn,
  input  logic    narrowSel,
  input  logic    rdCount,
  output strobe_t strobe
);

  logic rdCountQ;
  logic pending;
  logic evOk;
  logic clearCyc;
  logic busy;

  assign evOk     = eventIn & ~losIn & ~oofIn;
  assign clearCyc = rdCountQ & ~rdCount;
  assign busy     = rdCount | clearCyc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdCountQ <= 1'b0;
      pending  <= 1'b0;
    end else begin
      rdCountQ <= rdCount;
      if (clearCyc)
        pending <= 1'b0;
      else if (rdCount && evOk)
        pending <= 1'b1;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.incr    = evOk & ~busy;
    strobe.clear   = clearCyc;
    strobe.loadOne = clearCyc & (pending | evOk);
    strobe.capHigh = rdCount & ~rdCountQ & ~narrowSel;
  end

  // An inhibited event never reaches the count
  AST_INHIBIT_NO_INCR: assert property (@(posedge clk) disable iff (!rstN)
    (losIn || oofIn) |-> !strobe.incr && !(strobe.clear && strobe.loadOne && !pending)); // R5

  // Nothing is counted while a read is in progress
  AST_READ_NO_INCR: assert property (@(posedge clk) disable iff (!rstN)
    rdCount |-> !strobe.incr && !strobe.clear); // R1

endmodule

// File: rtl/perfCountPath.sv
module perfCountPath
  import perfCountPkg::*;
#(
  parameter int CntWidth  = 16,
  parameter int ByteWidth = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  logic                 modeM13,
  input  logic                 narrowSel,
  input  logic                 rdCount,
  input  logic                 rdHold,
  output logic [CntWidth-1:0]  cntVal,
  output logic [ByteWidth-1:0] rdData
);

  localparam int HighWidth = CntWidth - ByteWidth;
  localparam logic [CntWidth-1:0] WideMax   = '1;
  localparam logic [CntWidth-1:0] NarrowMax = {{HighWidth{1'b0}}, {ByteWidth{1'b1}}};

  logic [CntWidth-1:0]  cnt;
  logic [CntWidth-1:0]  cntInc;
  logic [CntWidth-1:0]  cntNext;
  logic [CntWidth-1:0]  widthMask;
  logic [HighWidth-1:0] holdReg;
  logic                 atMax;

  // Active-width mask: the upper lanes are cleared when the narrow width is selected
  generate
    for (genvar b = 0; b < CntWidth; b++) begin : g_mask
      if (b < ByteWidth) begin : g_low
        assign widthMask[b] = 1'b1;
      end else begin : g_high
        assign widthMask[b] = ~narrowSel;
      end
    end
  endgenerate

  assign atMax  = cnt == (narrowSel ? NarrowMax : WideMax);
  assign cntInc = (cnt + 1'b1) & widthMask;

  always_comb begin
    cntNext = cnt;
    if (strobe.clear)
      cntNext = {{(CntWidth-1){1'b0}}, strobe.loadOne};
    else if (strobe.incr) begin
      if (atMax && modeM13)
        cntNext = cnt;
      else
        cntNext = cntInc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      holdReg <= '0;
    end else begin
      cnt <= cntNext;
      if (strobe.capHigh)
        holdReg <= cnt[CntWidth-1:ByteWidth];
    end
  end

  always_comb begin
    if (rdCount)
      rdData = cnt[ByteWidth-1:0];
    else if (rdHold)
      rdData = holdReg[ByteWidth-1:0];
    else
      rdData = '0;
  end

  assign cntVal = cnt;

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incr && modeM13 && atMax) |=> cnt == $past(cnt)); // R9

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incr && narrowSel) |=> cnt[CntWidth-1:ByteWidth] == '0); // R8

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capHigh |=> $stable(holdReg)); // R10

endmodule

// File: rtl/perfCount.sv
module perfCount
  import perfCountPkg::*;
#(
  parameter int CntWidth  = 16,
  parameter int ByteWidth = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 eventIn,
  input  logic                 modeM13,
  input  logic                 narrowSel,
  input  logic                 losIn,
  input  logic                 oofIn,
  input  logic                 rdCount,
  input  logic                 rdHold,
  output logic [ByteWidth-1:0] rdData
);

  strobe_t             strobe;
  logic [CntWidth-1:0] cntVal;

  perfCountCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .eventIn   (eventIn),
    .losIn     (losIn),
    .oofIn     (oofIn),
    .narrowSel (narrowSel),
    .rdCount   (rdCount),
    .strobe    (strobe)
  );

  perfCountPath #(
    .CntWidth  (CntWidth),
    .ByteWidth (ByteWidth)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .modeM13   (modeM13),
    .narrowSel (narrowSel),
    .rdCount   (rdCount),
    .rdHold    (rdHold),
    .cntVal    (cntVal),
    .rdData    (rdData)
  );

  AST_FROZEN_IN_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdCount && $past(rdCount)) |-> $stable(cntVal)); // R1

  AST_CLEAR_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rdCount) && !rdCount) |=> cntVal <= 1); // R2

endmodule

// File: tb/perfCount_test.sv
module perfCount_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       eventIn, modeM13, narrowSel, losIn, oofIn, rdCount, rdHold;
  logic [7:0] rdData;
  int         total = 0;
  int         bad   = 0;

  always #10 clk = ~clk;  // 50 MHz

  perfCount uut (
    .clk(clk), .rstN(rstN), .eventIn(eventIn), .modeM13(modeM13),
    .narrowSel(narrowSel), .losIn(losIn), .oofIn(oofIn),
    .rdCount(rdCount), .rdHold(rdHold), .rdData(rdData)
  );

  typedef struct packed {
    logic [16:0] nEv;
    logic        los;
    logic        oof;
    logic        m13;
    logic        narrow;
    logic [7:0]  expLow;
    logic [7:0]  expHigh;
  } vec_t;

  localparam int NumVec = 11;
  localparam vec_t Vecs [NumVec] = '{
    '{17'd5,     1'b0, 1'b0, 1'b0, 1'b0, 8'h05, 8'h00},  // R6 basic
    '{17'd0,     1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00},  // R2 empty
    '{17'd300,   1'b0, 1'b0, 1'b0, 1'b0, 8'h2C, 8'h01},  // R6 R7
    '{17'd10,    1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00},  // R5 los
    '{17'd300,   1'b0, 1'b0, 1'b0, 1'b0, 8'h2C, 8'h01},  // R7
    '{17'd10,    1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h01},  // R5 oof, R7 narrow keeps hold
    '{17'd300,   1'b0, 1'b0, 1'b0, 1'b1, 8'h2C, 8'h01},  // R8 wrap
    '{17'd300,   1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h01},  // R9 narrow sat
    '{17'd65600, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF},  // R9 wide sat
    '{17'd65540, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04, 8'h00},  // R9 wide wrap
    '{17'd256,   1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h01}   // R9 below max
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); eventIn = 1'b1;
    end
    @(negedge clk); eventIn = 1'b0;
  endtask

  task automatic readLow(output logic [7:0] v);
    @(negedge clk); rdCount = 1'b1;
    #1 v = rdData;
    @(negedge clk); rdCount = 1'b0;
    @(negedge clk);
  endtask

  task automatic readHold(output logic [7:0] v);
    @(negedge clk); rdHold = 1'b1;
    #1 v = rdData;
    @(negedge clk); rdHold = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rstN = 1'b0; eventIn = 1'b0; modeM13 = 1'b0; narrowSel = 1'b0;
    losIn = 1'b0; oofIn = 1'b0; rdCount = 1'b0; rdHold = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state, R11
    #1 check("R11 idle data", rdData, 8'h00);
    readHold(v); check("R11 hold after reset", v, 8'h00);
    readLow(v);  check("R11 count after reset", v, 8'h00);

    // Vector table
    for (int k = 0; k < NumVec; k++) begin
      @(negedge clk);
      losIn = Vecs[k].los; oofIn = Vecs[k].oof;
      modeM13 = Vecs[k].m13; narrowSel = Vecs[k].narrow;
      pulses(int'(Vecs[k].nEv));
      losIn = 1'b0; oofIn = 1'b0;
      readLow(v);  check($sformatf("R6 R8 R9 vec%0d low", k), v, Vecs[k].expLow);
      readHold(v); check($sformatf("R7 vec%0d hold", k), v, Vecs[k].expHigh);
    end
    modeM13 = 1'b0; narrowSel = 1'b0;

    // R1 R3: multi-cycle read, event in the middle, count frozen
    pulses(3);
    @(negedge clk); rdCount = 1'b1;
    #1 check("R1 read value", rdData, 8'h03);
    @(negedge clk); eventIn = 1'b1;
    @(negedge clk); eventIn = 1'b0;
    #1 check("R1 frozen during read", rdData, 8'h03);
    @(negedge clk); rdCount = 1'b0;
    @(negedge clk);
    readLow(v); check("R3 retained event", v, 8'h01);

    // R3: event in the clearing cycle
    pulses(2);
    @(negedge clk); rdCount = 1'b1;
    @(negedge clk); rdCount = 1'b0; eventIn = 1'b1;
    @(negedge clk); eventIn = 1'b0;
    readLow(v); check("R3 clear-cycle event", v, 8'h01);

    // R4: events every cycle of a long read
    @(negedge clk); rdCount = 1'b1; eventIn = 1'b1;
    repeat (3) @(negedge clk);
    eventIn = 1'b0; rdCount = 1'b0;
    @(negedge clk);
    readLow(v); check("R4 single retained", v, 8'h01);

    // R5: inhibited event during read is not retained
    @(negedge clk); rdCount = 1'b1; losIn = 1'b1; eventIn = 1'b1;
    @(negedge clk); eventIn = 1'b0; rdCount = 1'b0; losIn = 1'b0;
    @(negedge clk);
    readLow(v); check("R5 inhibited during read", v, 8'h00);

    // R10: holding-register reads disturb nothing
    pulses(261);
    readLow(v);  check("R6 low of 261", v, 8'h05);
    readHold(v); check("R7 high of 261", v, 8'h01);
    pulses(7);
    readHold(v); check("R10 hold first", v, 8'h01);
    readHold(v); check("R10 hold second", v, 8'h01);
    readLow(v);  check("R10 count intact", v, 8'h07);
    readHold(v); check("R7 new capture", v, 8'h00);

    // R2: count is zero after a plain read
    pulses(4);
    readLow(v); check("R2 before clear", v, 8'h04);
    readLow(v); check("R2 after clear", v, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule